// File: doc/BRIEF.md
# ADC Register Access Sequencer

This block runs single-register read, write and read-modify-write operations against a delta-sigma SPI ADC that answers every command one frame late. It sits above a frame transceiver, which owns the bit-level SPI timing and the CRC arithmetic. For each operation the sequencer builds the command word, asks the transceiver for a frame, and follows up with NULL frames. The first NULL frame collects the delayed response (register contents or write acknowledge). The second NULL frame fetches the status word, whose input-CRC flag reports whether the device rejected a command frame.

A user presents an operation code, a 5-bit register address, write data and clear/set masks for one cycle while the block is idle. The block then stays busy. When it finishes it pulses `done` for one cycle with a 2-bit error code and, for reads, the register value. A read-modify-write is a full read sequence followed, only when the merged value differs from the old one, by a full write sequence. Each frame request is one `frm_start` pulse carrying the command word and an optional data word. The transceiver answers with `frm_done`, the upper 16 bits of the response word, and a failure flag.

Top module: `adc_reg_sequencer`

## Requirements
- R1: After reset `busy`, `done` and `frm_start` are 0 and `err_code` is 0.
- R2: A read (op 0, or the unused code 3) sends command 0xA000 OR (addr << 7) in frame 1 with no data word. Frames 2 and 3 carry the NULL command 0x0000 with no data word. `rd_data` takes the frame-2 response.
- R3: A write (op 1) sends 0x6000 OR (addr << 7) in frame 1 with `frm_has_data`=1 and the write data on `frm_word1`. The frame-2 response must equal 0x4000 OR (addr << 7).
- R4: Every read or write sequence uses exactly three frames, with never more than one outstanding. The third frame is sent even when the acknowledge did not match.
- R5: If bit 12 of the frame-3 response is set, the operation ends with code 3 (CRC). This takes priority over an acknowledge mismatch.
- R6: A read-modify-write (op 2) reads the register and computes (old AND NOT clear) OR set. It then writes that value with a full write sequence, six frames in all. `rd_data` holds the old value.
- R7: When the merged value equals the old value, the read-modify-write ends after the three read frames with code 0.
- R8: A transceiver failure (`frm_fail` with `frm_done`) ends the operation at once with code 1, and no further frame is requested.
- R9: Requests presented while `busy` is 1 are ignored. `frm_start` and `done` are single-cycle pulses, and `busy` falls in the cycle after `done`.
- R10: Error codes are 0 success, 1 transfer failure, 2 acknowledge mismatch, 3 input CRC error. They are valid while `done` is 1 and held until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| req_clr | input | 16 | Bits to clear in read-modify-write |
| req_set | input | 16 | Bits to set in read-modify-write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result code |
| rd_data | output | 16 | Register value read |
| frm_start | output | 1 | Frame request pulse |
| frm_cmd | output | 16 | Command word for the frame |
| frm_word1 | output | 16 | Data word for the frame |
| frm_has_data | output | 1 | Frame carries a data word |
| frm_done | input | 1 | Frame completed |
| frm_fail | input | 1 | Frame transfer failed |
| frm_resp | input | 16 | Upper 16 bits of the response word |

## Verification
The bench drives the sequencer from a device model. That model answers each frame according to the command of the frame before it, so a read that picked up the wrong response frame returns a visibly wrong value. Writes and reads go to distinct addresses, including address 31, which separates address placement errors from opcode errors. Single and combined injections of a bad acknowledge and a status CRC flag distinguish the two error codes and show their priority, and a frame count shows whether the trailing status frame was still sent. Merges that change and do not change the register separate the six-frame path from the early exit. A mid-sequence transfer failure and a request made while busy test abort and serialisation.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CMD_W      = 16;
  localparam int ADDR_W     = 5;
  localparam int ADDR_LSB   = 7;
  localparam int CRC_BIT    = 12;
  localparam int FIDX_W     = 2;
  localparam int FRAMES_SEQ = 3;

  localparam logic [CMD_W-1:0] CMD_NULL  = 16'h0000;
  localparam logic [CMD_W-1:0] CMD_RESET = 16'h0011;
  localparam logic [CMD_W-1:0] RD_BASE   = 16'hA000;
  localparam logic [CMD_W-1:0] WR_BASE   = 16'h6000;
  localparam logic [CMD_W-1:0] ACK_BASE  = 16'h4000;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    E_OK  = 2'd0,
    E_SPI = 2'd1,
    E_ACK = 2'd2,
    E_CRC = 2'd3
  } err_e;

  function automatic logic [CMD_W-1:0] f_addr_field(input logic [ADDR_W-1:0] a);
    return CMD_W'(a) << ADDR_LSB;
  endfunction

  function automatic logic [CMD_W-1:0] f_rd_cmd(input logic [ADDR_W-1:0] a);
    return RD_BASE | f_addr_field(a);
  endfunction

  function automatic logic [CMD_W-1:0] f_wr_cmd(input logic [ADDR_W-1:0] a);
    return WR_BASE | f_addr_field(a);
  endfunction

  function automatic logic [CMD_W-1:0] f_wr_ack(input logic [ADDR_W-1:0] a);
    return ACK_BASE | f_addr_field(a);
  endfunction

  function automatic logic [CMD_W-1:0] f_merge(input logic [CMD_W-1:0] old_v,
                                               input logic [CMD_W-1:0] clr_v,
                                               input logic [CMD_W-1:0] set_v);
    return (old_v & ~clr_v) | set_v;
  endfunction

endpackage

// File: rtl/seq_cmd_build.sv
module seq_cmd_build
  import adc_seq_pkg::*;
(
  input  logic [FIDX_W-1:0] fidx,
  input  logic              wr_phase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  wdata,
  output logic [CMD_W-1:0]  cmd,
  output logic [CMD_W-1:0]  word1,
  output logic              has_data
);

  logic first_frame;
  assign first_frame = (fidx == '0);

  always_comb begin
    cmd      = CMD_NULL;
    word1    = '0;
    has_data = 1'b0;
    if (first_frame) begin
      if (wr_phase) begin
        cmd      = f_wr_cmd(addr);
        word1    = wdata;
        has_data = 1'b1;
      end else begin
        cmd = f_rd_cmd(addr);
      end
    end
  end

endmodule

// File: rtl/seq_resp_check.sv
module seq_resp_check
  import adc_seq_pkg::*;
(
  input  logic [CMD_W-1:0]  resp,
  input  logic [ADDR_W-1:0] addr,
  output logic              ack_ok,
  output logic              crc_flag
);

  assign ack_ok   = (resp == f_wr_ack(addr));
  assign crc_flag = resp[CRC_BIT];

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_wdata,
  input  logic [CMD_W-1:0]  req_clr,
  input  logic [CMD_W-1:0]  req_set,
  input  logic              frm_done,
  input  logic              frm_fail,
  input  logic [CMD_W-1:0]  frm_resp,
  input  logic              ack_ok,
  input  logic              crc_flag,
  output logic [FIDX_W-1:0] fidx,
  output logic              wr_phase,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CMD_W-1:0]  wdata_q,
  output logic              send,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [CMD_W-1:0]  rd_data
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_DONE} state_e;

  state_e          state;
  logic            rmw_q;
  logic            ack_bad;
  logic [CMD_W-1:0] clr_q;
  logic [CMD_W-1:0] set_q;
  err_e            err_q;

  logic             accept;
  logic             frame_end;
  logic [CMD_W-1:0] merged;
  logic             merge_same;

  assign accept     = (state == S_IDLE) && req_valid;
  assign frame_end  = (state == S_WAIT) && frm_done;
  assign merged     = f_merge(rd_data, clr_q, set_q);
  assign merge_same = (merged == rd_data);

  assign send     = (state == S_SEND);
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);
  assign err_code = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      fidx     <= '0;
      wr_phase <= 1'b0;
      rmw_q    <= 1'b0;
      ack_bad  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      clr_q    <= '0;
      set_q    <= '0;
      err_q    <= E_OK;
      rd_data  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            clr_q    <= req_clr;
            set_q    <= req_set;
            rmw_q    <= (req_op == OP_RMW);
            wr_phase <= (req_op == OP_WRITE);
            fidx     <= '0;
            ack_bad  <= 1'b0;
            err_q    <= E_OK;
            state    <= S_SEND;
          end
        end
        S_SEND: state <= S_WAIT;
        S_WAIT: begin
          if (frame_end) begin
            if (frm_fail) begin
              err_q <= E_SPI;
              state <= S_DONE;
            end else if (fidx == FIDX_W'(0)) begin
              fidx  <= FIDX_W'(1);
              state <= S_SEND;
            end else if (fidx == FIDX_W'(1)) begin
              if (wr_phase) ack_bad <= !ack_ok;
              else          rd_data <= frm_resp;
              fidx  <= FIDX_W'(FRAMES_SEQ - 1);
              state <= S_SEND;
            end else begin
              if (crc_flag) begin
                err_q <= E_CRC;
                state <= S_DONE;
              end else if (ack_bad) begin
                err_q <= E_ACK;
                state <= S_DONE;
              end else if (rmw_q && !wr_phase && !merge_same) begin
                wdata_q  <= merged;
                wr_phase <= 1'b1;
                fidx     <= '0;
                state    <= S_SEND;
              end else begin
                state <= S_DONE;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_reg_sequencer.sv
module adc_reg_sequencer
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_wdata,
  input  logic [CMD_W-1:0]  req_clr,
  input  logic [CMD_W-1:0]  req_set,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [CMD_W-1:0]  rd_data,
  output logic              frm_start,
  output logic [CMD_W-1:0]  frm_cmd,
  output logic [CMD_W-1:0]  frm_word1,
  output logic              frm_has_data,
  input  logic              frm_done,
  input  logic              frm_fail,
  input  logic [CMD_W-1:0]  frm_resp
);

  logic [FIDX_W-1:0] fidx;
  logic              wr_phase;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  wdata_q;
  logic              ack_ok;
  logic              crc_flag;

  seq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_clr   (req_clr),
    .req_set   (req_set),
    .frm_done  (frm_done),
    .frm_fail  (frm_fail),
    .frm_resp  (frm_resp),
    .ack_ok    (ack_ok),
    .crc_flag  (crc_flag),
    .fidx      (fidx),
    .wr_phase  (wr_phase),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .send      (frm_start),
    .busy      (busy),
    .done      (done),
    .err_code  (err_code),
    .rd_data   (rd_data)
  );

  seq_cmd_build u_build (
    .fidx     (fidx),
    .wr_phase (wr_phase),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .cmd      (frm_cmd),
    .word1    (frm_word1),
    .has_data (frm_has_data)
  );

  seq_resp_check u_check (
    .resp     (frm_resp),
    .addr     (addr_q),
    .ack_ok   (ack_ok),
    .crc_flag (crc_flag)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic        busy,
  input logic        done,
  input logic [1:0]  err_code,
  input logic        frm_start,
  input logic [15:0] frm_cmd,
  input logic        frm_has_data,
  input logic        frm_done
);

  logic [2:0] fcnt;
  logic       out_q;
  logic [1:0] op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt  <= '0;
      out_q <= 1'b0;
      op_q  <= '0;
    end else begin
      if (req_valid && !busy) begin
        fcnt <= '0;
        op_q <= req_op;
      end else if (frm_start) begin
        fcnt <= fcnt + 3'd1;
      end
      if (frm_start)     out_q <= 1'b1;
      else if (frm_done) out_q <= 1'b0;
    end
  end

  p_start_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    frm_start |=> !frm_start);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (rst)
    frm_start |-> !out_q);

  p_null_follow_r2: assert property (@(posedge clk) disable iff (rst)
    frm_start && (fcnt == 3'd1 || fcnt == 3'd2 || fcnt == 3'd4 || fcnt == 3'd5)
      |-> (frm_cmd == 16'h0000) && !frm_has_data);

  p_three_frames_r4: assert property (@(posedge clk) disable iff (rst)
    done && (err_code != 2'd1) && (op_q != 2'd2) |-> fcnt == 3'd3);

  p_rmw_frames_r6: assert property (@(posedge clk) disable iff (rst)
    done && (err_code == 2'd0) && (op_q == 2'd2) |-> (fcnt == 3'd3 || fcnt == 3'd6));

  p_crc_after_third_r5: assert property (@(posedge clk) disable iff (rst)
    done && (err_code == 2'd3) |-> (fcnt == 3'd3 || fcnt == 3'd6));

endmodule

bind adc_reg_sequencer adc_seq_checker u_seq_checker (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .busy         (busy),
  .done         (done),
  .err_code     (err_code),
  .frm_start    (frm_start),
  .frm_cmd      (frm_cmd),
  .frm_has_data (frm_has_data),
  .frm_done     (frm_done)
);

// File: tb/test_adc_reg_sequencer.sv
`timescale 1ns/1ps
module test_adc_reg_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, req_clr = '0, req_set = '0;
  logic        busy, done;
  logic [1:0]  err_code;
  logic [15:0] rd_data;
  logic        frm_start;
  logic [15:0] frm_cmd, frm_word1;
  logic        frm_has_data;
  logic        frm_done = 1'b0;
  logic        frm_fail = 1'b0;
  logic [15:0] frm_resp = '0;

  always #4 clk = ~clk;

  adc_reg_sequencer i_adc_reg_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_clr(req_clr),
    .req_set(req_set), .busy(busy), .done(done), .err_code(err_code),
    .rd_data(rd_data), .frm_start(frm_start), .frm_cmd(frm_cmd),
    .frm_word1(frm_word1), .frm_has_data(frm_has_data),
    .frm_done(frm_done), .frm_fail(frm_fail), .frm_resp(frm_resp)
  );

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // device model: expected frame queues and register contents
  logic [15:0] q_cmd[$];
  logic [15:0] q_w1[$];
  bit          q_hd[$];
  logic [15:0] dev_regs [32];
  logic [15:0] prev_cmd = 16'h0000;
  int fno = 0;
  int crc_at = 0, badack_at = 0, fail_at = 0;
  int lat = 0;
  bit pend = 0;
  logic [15:0] cur_cmd, cur_w1;
  bit cur_hd;
  int cur_no;

  initial for (int i = 0; i < 32; i++) dev_regs[i] = 16'(i * 257);

  always @(negedge clk) begin
    frm_done <= 1'b0;
    frm_fail <= 1'b0;
    if (pend) begin
      if (lat == 0) begin
        logic [15:0] r;
        pend = 0;
        if (prev_cmd[15:13] == 3'b101)
          r = dev_regs[prev_cmd[11:7]];
        else if (prev_cmd[15:13] == 3'b011)
          r = (16'h4000 + 16'(prev_cmd[11:7]) * 16'd128) ^ ((badack_at == cur_no) ? 16'h0001 : 16'h0000);
        else
          r = 16'h0005 | ((crc_at == cur_no) ? 16'h1000 : 16'h0000);
        frm_resp <= r;
        frm_done <= 1'b1;
        frm_fail <= (fail_at == cur_no);
        prev_cmd = cur_cmd;
        if (cur_hd && cur_cmd[15:13] == 3'b011) dev_regs[cur_cmd[11:7]] = cur_w1;
      end else lat--;
    end
    if (frm_start) begin
      fno++;
      cur_no = fno; cur_cmd = frm_cmd; cur_w1 = frm_word1; cur_hd = frm_has_data;
      pend = 1; lat = 2;
      if (q_cmd.size() == 0) begin
        check(0, tag, "unexpected frame cmd", frm_cmd, 0);
      end else begin
        logic [15:0] ec, ew; bit eh;
        ec = q_cmd.pop_front(); ew = q_w1.pop_front(); eh = q_hd.pop_front();
        check(frm_cmd == ec, tag, "frame command", frm_cmd, ec);
        check(frm_has_data == eh, tag, "frame data flag", frm_has_data, eh);
        if (eh) check(frm_word1 == ew, tag, "frame data word", frm_word1, ew);
      end
    end
  end

  task automatic push_rd(input int a);
    q_cmd.push_back(16'hA000 + 16'(a) * 16'd128); q_w1.push_back(0); q_hd.push_back(0);
    repeat (2) begin q_cmd.push_back(0); q_w1.push_back(0); q_hd.push_back(0); end
  endtask

  task automatic push_wr(input int a, input logic [15:0] d);
    q_cmd.push_back(16'h6000 + 16'(a) * 16'd128); q_w1.push_back(d); q_hd.push_back(1);
    repeat (2) begin q_cmd.push_back(0); q_w1.push_back(0); q_hd.push_back(0); end
  endtask

  task automatic run_op(input int op, input int a, input logic [15:0] wd,
                        input logic [15:0] cl, input logic [15:0] st,
                        input int exp_frames, input int exp_err,
                        input bit chk_rd, input logic [15:0] exp_rd, input bit poke);
    int n;
    fno = 0;
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_addr = 5'(a);
    req_wdata = wd; req_clr = cl; req_set = st;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_op = 2'd1; req_addr = 5'd9; req_wdata = 16'hDEAD;
      @(negedge clk);
      req_valid = 0;
    end
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    check(done == 1'b1, tag, "done seen", done, 1);
    check(int'(err_code) == exp_err, tag, "error code", err_code, exp_err);
    check(fno == exp_frames, tag, "frame count", fno, exp_frames);
    if (chk_rd) check(rd_data == exp_rd, tag, "read data", rd_data, exp_rd);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9", "done pulse and idle", {done, busy}, 0);
    crc_at = 0; badack_at = 0; fail_at = 0;
    q_cmd.delete(); q_w1.delete(); q_hd.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && frm_start == 0, "R1", "reset outputs",
          {busy, done, frm_start}, 0);
    check(err_code == 0, "R1", "reset error code", err_code, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    tag = "R3"; push_wr(5, 16'hBEEF);
    run_op(1, 5, 16'hBEEF, 0, 0, 3, 0, 0, 0, 0);
    tag = "R2"; push_rd(5);
    run_op(0, 5, 0, 0, 0, 3, 0, 1, 16'hBEEF, 0);
    tag = "R3"; push_wr(31, 16'h1234);
    run_op(1, 31, 16'h1234, 0, 0, 3, 0, 0, 0, 0);
    tag = "R2"; push_rd(31);
    run_op(0, 31, 0, 0, 0, 3, 0, 1, 16'h1234, 0);
    // R4 R10: bad acknowledge still sends third frame, code 2
    tag = "R4"; push_wr(6, 16'h5555); badack_at = 2;
    run_op(1, 6, 16'h5555, 0, 0, 3, 2, 0, 0, 0);
    // R5: CRC wins over acknowledge mismatch
    tag = "R5"; push_wr(6, 16'h5555); badack_at = 2; crc_at = 3;
    run_op(1, 6, 16'h5555, 0, 0, 3, 3, 0, 0, 0);
    tag = "R5"; push_rd(7); crc_at = 3;
    run_op(0, 7, 0, 0, 0, 3, 3, 0, 0, 0);
    // R6 read-modify-write with change
    tag = "R6"; push_wr(3, 16'h00F0);
    run_op(1, 3, 16'h00F0, 0, 0, 3, 0, 0, 0, 0);
    tag = "R6"; push_rd(3); push_wr(3, (16'h00F0 & ~16'h0030) | 16'h0101);
    run_op(2, 3, 0, 16'h0030, 16'h0101, 6, 0, 1, 16'h00F0, 0);
    tag = "R6"; push_rd(3);
    run_op(0, 3, 0, 0, 0, 3, 0, 1, 16'h01C1, 0);
    // R7 no change: write skipped
    tag = "R7"; push_rd(3);
    run_op(2, 3, 0, 16'h0000, 16'h0001, 3, 0, 1, 16'h01C1, 0);
    // R8 transfer failure on frame 2
    tag = "R8"; push_rd(2); fail_at = 2;
    run_op(0, 2, 0, 0, 0, 2, 1, 0, 0, 0);
    // R5 R6: CRC error in read phase stops before the write
    tag = "R6"; push_rd(4); crc_at = 3;
    run_op(2, 4, 0, 16'hFFFF, 16'h0000, 3, 3, 0, 0, 0);
    // R9 request while busy is ignored
    tag = "R9"; push_rd(8);
    run_op(0, 8, 0, 0, 0, 3, 0, 1, 16'h0808, 1);
    tag = "R9"; push_rd(9);
    run_op(0, 9, 0, 0, 0, 3, 0, 1, 16'h0909, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule